// File: doc/BRIEF.md
# DRAM Address Multiplexer with Strobe Steering

This block sits between a memory controller's access sequencer and an array of dynamic RAM devices. When an access starts it captures the row address, the column address, the bank number, the grouping mode and the write flag. It then drives the shared DRAM address bus with the row, raises the row strobes of the selected group, switches the bus to the column, and raises the column strobes of the enabled byte lanes. While a page or burst access is open, a step input advances the held column address by one in place, so later beats need no new column from the requester.

Refresh timing is produced elsewhere. This block only obeys a refresh flag: the flag places the supplied refresh address on the bus, holds off the start of any new access, and raises every row strobe while no access is open. A grouping mode picks how the bank number maps onto the four strobe pairs. Per-lane enables gate the column strobes, which allows byte writes on a 32-bit word and toggling of the column strobes for page or nibble cycles. An optional setting adds a one-cycle gap before the column strobes on writes.

Top module: `dram_addr_mux`

## Requirements
- R1: An access starts at a rising edge that sees `acc_req`=1, `rfsh_active`=0 and no open access. That edge captures `row_in`, `col_in`, `bank_in`, `cfg_mode` and `wr_in`. During the row phase, the first cycle after the start, `q_addr` shows the captured row. After that it shows the captured column. Changes on `row_in`/`col_in` after the start have no effect on `q_addr`.
- R2: While `rfsh_active`=1, `q_addr` equals `rfsh_addr`. While `rfsh_active`=1 and no access is open, `ras_o`=4'b1111, `cas_o`=0, and no access starts.
- R3: From the row phase to the end of the access, `ras_o` holds the group mask for the captured mode and bank. Mode 0: only bit `bank`. Mode 1: lanes 0,1 when bank[1]=0, lanes 2,3 when bank[1]=1. Mode 2: all four lanes. Mode 3: lanes 0,2 when bank[0]=0, lanes 1,3 when bank[0]=1.
- R4: In the column strobe phase, `cas_o` = group mask AND `lane_en` (bit i is lane i), and it follows `lane_en` changes in the same cycle without waiting for a clock. `cas_o` is 0 in every other phase.
- R5: At a rising edge in the column part of an access with `col_step`=1 and `rfsh_active`=0, the held column increases by one. When `rfsh_active`=1, `col_step` has no effect on the held column.
- R6: Incrementing column all-ones wraps to zero inside `ADDR_W` bits. The row is not changed.
- R7: When `cfg_wr_dly`=1 and the captured access is a write, the column is on `q_addr` for one cycle with `cas_o`=0 before the column strobes assert. Reads, and writes with `cfg_wr_dly`=0, assert the column strobes in the cycle right after the row phase.
- R8: `we_o` equals the captured write flag while an access is open and is 0 otherwise.
- R9: After reset, `ras_o`, `cas_o` and `we_o` are 0 and `q_addr` is 0.
- R10: A rising edge that sees `acc_req`=0 closes any open access. In the next cycle `ras_o`, `cas_o` and `we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Bank grouping mode (see R3) |
| cfg_wr_dly | input | 1 | Add one cycle before column strobes on writes |
| acc_req | input | 1 | Access request, held high for the whole access |
| wr_in | input | 1 | Access is a write |
| row_in | input | ADDR_W (10) | Row address |
| col_in | input | ADDR_W (10) | Column address |
| bank_in | input | BANK_W (2) | Bank number |
| lane_en | input | LANES (4) | Per-byte-lane column strobe enables |
| col_step | input | 1 | Advance held column by one |
| rfsh_active | input | 1 | Refresh in progress |
| rfsh_addr | input | ADDR_W (10) | Refresh row address |
| q_addr | output | ADDR_W (10) | Multiplexed DRAM address |
| ras_o | output | LANES (4) | Row strobes, active high |
| cas_o | output | LANES (4) | Column strobes, active high |
| we_o | output | 1 | Write enable, active high |

## Verification
The hardest state to reach is a column increment that wraps. It needs an access that is already open and past its row phase, with a column near all-ones, so that several step pulses can be applied in a row without ending the access. The bench opens such an access right after a refresh window. This also confirms that the request was held off during refresh and then started. It then steps across the wrap boundary, raises refresh with a step pending to show that the step is ignored, and toggles the lane enables between clock edges.

// File: rtl/dam_pkg.sv
package dam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROW   = 2'd1,
    ST_CWAIT = 2'd2,
    ST_COL   = 2'd3
  } dam_state_e;
endpackage

// File: rtl/dam_seq.sv
module dam_seq #(
  parameter int ADDR_W = 10,
  parameter int BANK_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_req,
  input  logic                      rfsh_active,
  input  logic                      wr_in,
  input  logic                      cfg_wr_dly,
  input  logic [1:0]                cfg_mode,
  input  logic [ADDR_W-1:0]         row_in,
  input  logic [BANK_W-1:0]         bank_in,
  output dam_pkg::dam_state_e       st,
  output logic                      start,
  output logic [ADDR_W-1:0]         row_q,
  output logic [BANK_W-1:0]         bank_q,
  output logic [1:0]                mode_q,
  output logic                      wr_q
);
  import dam_pkg::*;

  dam_state_e st_q, st_d;

  assign start = (st_q == ST_IDLE) && acc_req && !rfsh_active;

  // next-state process
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_ROW;
      ST_ROW: begin
        if (!acc_req)                st_d = ST_IDLE;
        else if (wr_q && cfg_wr_dly) st_d = ST_CWAIT;
        else                         st_d = ST_COL;
      end
      ST_CWAIT: st_d = acc_req ? ST_COL : ST_IDLE;
      ST_COL:   st_d = acc_req ? ST_COL : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // capture registers, enabled at access start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      bank_q <= '0;
      mode_q <= '0;
      wr_q   <= 1'b0;
    end else if (start) begin
      row_q  <= row_in;
      bank_q <= bank_in;
      mode_q <= cfg_mode;
      wr_q   <= wr_in;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/dam_col_ctr.sv
module dam_col_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  output logic [ADDR_W-1:0] col_q
);
  logic [ADDR_W-1:0] col_d;
  logic              col_en;

  always_comb begin
    col_en = load | step_en;
    col_d  = load ? load_val : col_q + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_d;
  end
endmodule

// File: rtl/dam_strobe.sv
module dam_strobe #(
  parameter int LANES  = 4,
  parameter int BANK_W = 2
) (
  input  dam_pkg::dam_state_e st,
  input  logic [1:0]          mode_q,
  input  logic [BANK_W-1:0]   bank_q,
  input  logic [LANES-1:0]    lane_en,
  input  logic                rfsh_active,
  output logic [LANES-1:0]    ras_o,
  output logic [LANES-1:0]    cas_o
);
  import dam_pkg::*;

  logic [LANES-1:0] grp;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [BANK_W-1:0] idx;
      idx = BANK_W'(i);
      unique case (mode_q)
        2'd0:    grp[i] = (idx == bank_q);
        2'd1:    grp[i] = (idx[BANK_W-1] == bank_q[BANK_W-1]);
        2'd2:    grp[i] = 1'b1;
        default: grp[i] = (idx[0] == bank_q[0]);
      endcase
    end
  end

  always_comb begin
    if (st != ST_IDLE)   ras_o = grp;
    else if (rfsh_active) ras_o = '1;
    else                 ras_o = '0;
    cas_o = (st == ST_COL) ? (grp & lane_en) : '0;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter  int ADDR_W = 10,
  parameter  int LANES  = 4,
  localparam int BANK_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_wr_dly,
  input  logic              acc_req,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] row_in,
  input  logic [ADDR_W-1:0] col_in,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [LANES-1:0]  lane_en,
  input  logic              col_step,
  input  logic              rfsh_active,
  input  logic [ADDR_W-1:0] rfsh_addr,
  output logic [ADDR_W-1:0] q_addr,
  output logic [LANES-1:0]  ras_o,
  output logic [LANES-1:0]  cas_o,
  output logic              we_o
);
  import dam_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ok <= rst_s1;
    end
  end

  dam_state_e        st;
  logic              start;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [BANK_W-1:0] bank_q;
  logic [1:0]        mode_q;
  logic              wr_q;
  logic              col_phase;
  logic              step_en;

  dam_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst_n(rst_ok), .acc_req(acc_req), .rfsh_active(rfsh_active),
    .wr_in(wr_in), .cfg_wr_dly(cfg_wr_dly), .cfg_mode(cfg_mode),
    .row_in(row_in), .bank_in(bank_in), .st(st), .start(start),
    .row_q(row_q), .bank_q(bank_q), .mode_q(mode_q), .wr_q(wr_q)
  );

  assign col_phase = (st == ST_CWAIT) || (st == ST_COL);
  assign step_en   = col_phase && col_step && !rfsh_active;

  dam_col_ctr #(.ADDR_W(ADDR_W)) u_col (
    .clk(clk), .rst_n(rst_ok), .load(start), .load_val(col_in),
    .step_en(step_en), .col_q(col_q)
  );

  dam_strobe #(.LANES(LANES), .BANK_W(BANK_W)) u_stb (
    .st(st), .mode_q(mode_q), .bank_q(bank_q), .lane_en(lane_en),
    .rfsh_active(rfsh_active), .ras_o(ras_o), .cas_o(cas_o)
  );

  always_comb begin
    if (rfsh_active)    q_addr = rfsh_addr;
    else if (col_phase) q_addr = col_q;
    else                q_addr = row_q;
    we_o = (st != ST_IDLE) && wr_q;
  end
endmodule

// File: rtl/dam_check.sv
module dam_check #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic                clk,
  input logic                rst_ok,
  input logic [1:0]          cfg_mode,
  input logic                cfg_wr_dly,
  input logic                acc_req,
  input logic                col_step,
  input logic                rfsh_active,
  input logic [ADDR_W-1:0]   q_addr,
  input logic [LANES-1:0]    ras_o,
  input logic [LANES-1:0]    cas_o,
  input logic                we_o,
  input dam_pkg::dam_state_e st
);
  import dam_pkg::*;

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_ok)
    (cas_o & ~ras_o) == '0);  // R4

  AST_MODE0_SINGLE_RAS: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_mode == 2'd0 && !rfsh_active) |-> $onehot0(ras_o));  // R3

  AST_RAS_HELD: assert property (@(posedge clk) disable iff (!rst_ok)
    (st != ST_IDLE && acc_req) |=> (st == ST_IDLE || $stable(ras_o)));  // R3

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_ok)
    ((|cas_o) && col_step && acc_req && !rfsh_active)
      |=> (rfsh_active || q_addr == $past(q_addr) + 1'b1));  // R5

  AST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_ok)
    (st == ST_ROW && we_o && cfg_wr_dly && acc_req) |=> cas_o == '0);  // R7

  AST_WE_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_ok)
    (ras_o == '0) |-> !we_o);  // R8

  AST_CLOSE_DROPS_CAS: assert property (@(posedge clk) disable iff (!rst_ok)
    !acc_req |=> cas_o == '0);  // R10
endmodule

bind dram_addr_mux dam_check #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .cfg_mode(cfg_mode), .cfg_wr_dly(cfg_wr_dly),
  .acc_req(acc_req), .col_step(col_step), .rfsh_active(rfsh_active),
  .q_addr(q_addr), .ras_o(ras_o), .cas_o(cas_o), .we_o(we_o), .st(st)
);

// File: tb/dram_addr_mux_test.sv
module dram_addr_mux_test;
  localparam int AW = 10;
  localparam int LN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_mode = '0;
  logic          cfg_wr_dly = 1'b0;
  logic          acc_req = 1'b0;
  logic          wr_in = 1'b0;
  logic [AW-1:0] row_in = '0;
  logic [AW-1:0] col_in = '0;
  logic [1:0]    bank_in = '0;
  logic [LN-1:0] lane_en = '0;
  logic          col_step = 1'b0;
  logic          rfsh_active = 1'b0;
  logic [AW-1:0] rfsh_addr = '0;
  logic [AW-1:0] q_addr;
  logic [LN-1:0] ras_o, cas_o;
  logic          we_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  dram_addr_mux #(.ADDR_W(AW), .LANES(LN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wr_dly(cfg_wr_dly),
    .acc_req(acc_req), .wr_in(wr_in), .row_in(row_in), .col_in(col_in),
    .bank_in(bank_in), .lane_en(lane_en), .col_step(col_step),
    .rfsh_active(rfsh_active), .rfsh_addr(rfsh_addr), .q_addr(q_addr),
    .ras_o(ras_o), .cas_o(cas_o), .we_o(we_o)
  );

  // {mode[2], bank[2], lanes[4], wr, dly, exp_ras[4], exp_cas[4]}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 2'd2, 4'b1111, 1'b0, 1'b0, 4'b0100, 4'b0100},
    {2'd1, 2'd3, 4'b1111, 1'b1, 1'b0, 4'b1100, 4'b1100},
    {2'd1, 2'd1, 4'b0110, 1'b0, 1'b0, 4'b0011, 4'b0010},
    {2'd2, 2'd0, 4'b1010, 1'b1, 1'b1, 4'b1111, 4'b1010},
    {2'd3, 2'd1, 4'b1111, 1'b0, 1'b0, 4'b1010, 4'b1010},
    {2'd3, 2'd2, 4'b0111, 1'b0, 1'b0, 4'b0101, 4'b0101},
    {2'd0, 2'd0, 4'b0000, 1'b0, 1'b0, 4'b0001, 4'b0000},
    {2'd2, 2'd3, 4'b0001, 1'b1, 1'b1, 4'b1111, 4'b0001}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check("R9 ras", 32'(ras_o), 0);
    check("R9 cas", 32'(cas_o), 0);
    check("R9 we", 32'(we_o), 0);
    check("R9 q", 32'(q_addr), 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] r, c;
      logic wr, dly;
      r = AW'(10'h100 + i * 3);
      c = AW'(10'h020 + i);
      wr = VEC[i][9];
      dly = VEC[i][8];
      cfg_mode = VEC[i][17:16];
      bank_in = VEC[i][15:14];
      lane_en = VEC[i][13:10];
      wr_in = wr;
      cfg_wr_dly = dly;
      row_in = r;
      col_in = c;
      acc_req = 1'b1;
      tick();
      check($sformatf("R3 ras row phase v%0d", i), 32'(ras_o), 32'(VEC[i][7:4]));
      check($sformatf("R1 row addr v%0d", i), 32'(q_addr), 32'(r));
      check($sformatf("R4 no cas in row v%0d", i), 32'(cas_o), 0);
      check($sformatf("R8 we v%0d", i), 32'(we_o), 32'(wr));
      row_in = 10'h3C3;
      col_in = 10'h155;
      wr_in = ~wr;
      tick();
      if (wr && dly) begin
        check($sformatf("R7 gap cas v%0d", i), 32'(cas_o), 0);
        check($sformatf("R7 gap addr v%0d", i), 32'(q_addr), 32'(c));
        tick();
      end
      check($sformatf("R4 cas v%0d", i), 32'(cas_o), 32'(VEC[i][3:0]));
      check($sformatf("R1 col addr v%0d", i), 32'(q_addr), 32'(c));
      check($sformatf("R3 ras col phase v%0d", i), 32'(ras_o), 32'(VEC[i][7:4]));
      check($sformatf("R8 we held v%0d", i), 32'(we_o), 32'(wr));
      acc_req = 1'b0;
      tick();
      check($sformatf("R10 ras v%0d", i), 32'(ras_o), 0);
      check($sformatf("R10 cas v%0d", i), 32'(cas_o), 0);
      check($sformatf("R10 we v%0d", i), 32'(we_o), 0);
    end

    // refresh holds off an access
    cfg_mode = 2'd0; bank_in = 2'd1; lane_en = 4'b1111;
    wr_in = 1'b0; cfg_wr_dly = 1'b0;
    row_in = 10'h0F0; col_in = 10'h3FE;
    rfsh_addr = 10'h2AA;
    rfsh_active = 1'b1;
    acc_req = 1'b1;
    #1;
    check("R2 refresh addr", 32'(q_addr), 32'h2AA);
    check("R2 refresh ras", 32'(ras_o), 32'hF);
    tick();
    check("R2 no start during refresh", 32'(ras_o), 32'hF);
    check("R2 no cas during refresh", 32'(cas_o), 0);
    rfsh_active = 1'b0;
    tick();
    check("R2 start after refresh", 32'(ras_o), 32'h2);
    check("R1 row after refresh", 32'(q_addr), 32'h0F0);
    tick();
    check("R1 col start", 32'(q_addr), 32'h3FE);

    // column stepping and wrap
    col_step = 1'b1;
    tick();
    check("R5 step", 32'(q_addr), 32'h3FF);
    tick();
    check("R6 wrap", 32'(q_addr), 32'h000);
    col_step = 1'b0;
    tick();
    check("R5 no step", 32'(q_addr), 32'h000);
    check("R6 ras unchanged after wrap", 32'(ras_o), 32'h2);

    // step ignored during refresh
    rfsh_active = 1'b1;
    col_step = 1'b1;
    #1;
    check("R2 refresh addr mid access", 32'(q_addr), 32'h2AA);
    tick();
    rfsh_active = 1'b0;
    col_step = 1'b0;
    #1;
    check("R5 step ignored in refresh", 32'(q_addr), 32'h000);

    // lane toggling without a clock edge
    lane_en = 4'b0000;
    #1;
    check("R4 lane off", 32'(cas_o), 0);
    lane_en = 4'b0010;
    #1;
    check("R4 lane on", 32'(cas_o), 32'h2);
    lane_en = 4'b0100;
    #1;
    check("R4 lane outside group", 32'(cas_o), 0);
    acc_req = 1'b0;
    tick();
    check("R10 close", 32'(ras_o), 0);
    check("R1 idle shows row", 32'(q_addr), 32'h0F0);

    // reset in the middle of an access
    acc_req = 1'b1;
    tick();
    rst_n = 1'b0;
    #1;
    check("R9 async reset ras", 32'(ras_o), 0);
    check("R9 async reset q", 32'(q_addr), 0);
    acc_req = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule